// File: doc/BRIEF.md
# Serial Line Error Flag Register

This block holds the sticky error and event flags of a LIN/UART controller in one 8-bit register that software reads. The receive and transmit logic report each event as a one-cycle pulse: bit error, overrun, framing error, expansion bit detected, ID match and parity error. The bit error, overrun and framing pulses are gated by their own detection enables. The framing pulse is also gated in the low-power snooze state, where it counts only when reception may start from stop and error interrupts are not suppressed.

Software clears chosen flags with one 8-bit write. A 0 in a bit position clears that flag and a 1 leaves it as it is. While the controller is held in LIN reset mode, the register is forced to zero, ignores writes and ignores detection pulses.

Top module: `lin_err_status`

## Requirements
- R1: After reset `rd_data` is 0x00. The flag positions are: bit 0 bit error, bit 2 overrun, bit 3 framing, bit 4 expansion bit, bit 5 ID match, bit 6 parity. A pulse sampled at a clock edge shows in `rd_data` right after that edge.
- R2: Bits 1 and 7 of `rd_data` always read 0, whatever is written to them.
- R3: On a write, a 0 in a flag position clears that flag and a 1 leaves it unchanged.
- R4: `det_bit` sets bit 0 only when `en_bit` is 1.
- R5: `det_ovr` sets bit 2 only when `en_ovr` is 1.
- R6: `det_frm` sets bit 3 only when `en_frm` is 1. While `snooze` is 1, it also requires `wake_rx_en` = 1 and `err_irq_off` = 0.
- R7: `det_exp`, `det_idm` and `det_par` set bits 4, 5 and 6 directly, with no enable.
- R8: When a detection and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: While `lin_rst_mode` is 1, the register reads 0x00 from the next edge onward, and writes and detection pulses have no effect. It is still 0x00 after reset mode is left.
- R10: Each `flag_*` output equals its bit of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin_rst_mode | input | 1 | Controller is in LIN reset mode |
| snooze | input | 1 | Low-power snooze state active |
| wake_rx_en | input | 1 | Reception may start from stop |
| err_irq_off | input | 1 | Error interrupt generation suppressed |
| en_bit | input | 1 | Bit error detection enable |
| en_ovr | input | 1 | Overrun detection enable |
| en_frm | input | 1 | Framing detection enable |
| det_bit | input | 1 | Bit error pulse |
| det_ovr | input | 1 | Overrun pulse |
| det_frm | input | 1 | Framing error pulse |
| det_exp | input | 1 | Expansion bit pulse |
| det_idm | input | 1 | ID match pulse |
| det_par | input | 1 | Parity error pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write value (0 clears, 1 keeps) |
| rd_data | output | 8 | Register value |
| flag_bit | output | 1 | Bit error flag |
| flag_ovr | output | 1 | Overrun flag |
| flag_frm | output | 1 | Framing flag |
| flag_exp | output | 1 | Expansion bit flag |
| flag_idm | output | 1 | ID match flag |
| flag_par | output | 1 | Parity flag |

## Verification
The assertions assume that detection pulses and write strobes are sampled synchronously on the clock edge. They also assume the enables and the snooze controls are stable around the edge where a pulse is sampled. The bench meets these conditions by changing every input on the falling edge and holding each pulse for exactly one cycle. It also takes the register out of reset mode and clears it before each scenario, so that every property's precondition starts from a known register value.

// File: rtl/lin_err_status_pkg.sv
package lin_err_status_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned N_FLAGS = 6;

    // flag index -> register bit position (software decodes these)
    function automatic int unsigned flag_pos(input int unsigned idx);
        case (idx)
            0: flag_pos = 0;  // bit error
            1: flag_pos = 2;  // overrun
            2: flag_pos = 3;  // framing
            3: flag_pos = 4;  // expansion bit
            4: flag_pos = 5;  // ID match
            default: flag_pos = 6; // parity
        endcase
    endfunction

    typedef struct packed {
        logic par;
        logic idm;
        logic exp;
        logic frm;
        logic ovr;
        logic bite;
    } evt_t;
endpackage

// File: rtl/lin_err_status_qual.sv
module lin_err_status_qual
    import lin_err_status_pkg::*;
(
    input  evt_t det,
    input  logic en_bit,
    input  logic en_ovr,
    input  logic en_frm,
    input  logic snooze,
    input  logic wake_rx_en,
    input  logic err_irq_off,
    input  logic lock,
    output evt_t set
);
    logic frm_allowed;

    always_comb begin
        frm_allowed = en_frm && (!snooze || (wake_rx_en && !err_irq_off));
        set      = '0;
        if (!lock) begin
            set.bite = det.bite && en_bit;
            set.ovr  = det.ovr  && en_ovr;
            set.frm  = det.frm  && frm_allowed;
            set.exp  = det.exp;
            set.idm  = det.idm;
            set.par  = det.par;
        end
    end
endmodule

// File: rtl/lin_err_status_cell.sv
module lin_err_status_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    input  logic set,
    input  logic wr_en,
    input  logic wr_bit,
    output logic q
);
    logic flag_d;
    logic flag_q;

    always_comb begin
        flag_d = flag_q;
        if (lock)
            flag_d = 1'b0;
        else if (set)
            flag_d = 1'b1;
        else if (wr_en && !wr_bit)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign q = flag_q;
endmodule

// File: rtl/lin_err_status.sv
module lin_err_status
    import lin_err_status_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lin_rst_mode,
    input  logic       snooze,
    input  logic       wake_rx_en,
    input  logic       err_irq_off,
    input  logic       en_bit,
    input  logic       en_ovr,
    input  logic       en_frm,
    input  logic       det_bit,
    input  logic       det_ovr,
    input  logic       det_frm,
    input  logic       det_exp,
    input  logic       det_idm,
    input  logic       det_par,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       flag_bit,
    output logic       flag_ovr,
    output logic       flag_frm,
    output logic       flag_exp,
    output logic       flag_idm,
    output logic       flag_par
);
    evt_t det_vec;
    evt_t set_vec;
    evt_t flags;
    logic [REG_W-1:0] rd_d;

    always_comb begin
        det_vec.bite = det_bit;
        det_vec.ovr  = det_ovr;
        det_vec.frm  = det_frm;
        det_vec.exp  = det_exp;
        det_vec.idm  = det_idm;
        det_vec.par  = det_par;
    end

    lin_err_status_qual u_qual (
        .det         (det_vec),
        .en_bit      (en_bit),
        .en_ovr      (en_ovr),
        .en_frm      (en_frm),
        .snooze      (snooze),
        .wake_rx_en  (wake_rx_en),
        .err_irq_off (err_irq_off),
        .lock        (lin_rst_mode),
        .set         (set_vec)
    );

    for (genvar gi = 0; gi < N_FLAGS; gi++) begin : g_cell
        localparam int unsigned POS = flag_pos(gi);
        lin_err_status_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .lock   (lin_rst_mode),
            .set    (set_vec[gi]),
            .wr_en  (wr_en),
            .wr_bit (wr_data[POS]),
            .q      (flags[gi])
        );
    end

    always_comb begin
        rd_d = '0;
        for (int i = 0; i < N_FLAGS; i++)
            rd_d[flag_pos(i)] = flags[i];
    end

    assign rd_data  = rd_d;
    assign flag_bit = flags.bite;
    assign flag_ovr = flags.ovr;
    assign flag_frm = flags.frm;
    assign flag_exp = flags.exp;
    assign flag_idm = flags.idm;
    assign flag_par = flags.par;
endmodule

// File: rtl/lin_err_status_chk.sv
module lin_err_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lin_rst_mode,
    input logic       snooze,
    input logic       wake_rx_en,
    input logic       err_irq_off,
    input logic       en_bit,
    input logic       det_bit,
    input logic       det_ovr,
    input logic       det_frm,
    input logic       det_par,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       flag_par,
    input logic       flag_frm
);
    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] == 1'b0) && (rd_data[7] == 1'b0));

    p_lock_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lin_rst_mode |=> (rd_data == 8'h00));

    p_bit_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lin_rst_mode && det_bit && en_bit) |=> rd_data[0]);

    p_bit_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[0] && !(det_bit && en_bit)) |=> !rd_data[0]);

    p_frm_snooze_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (snooze && (!wake_rx_en || err_irq_off) && !rd_data[3]) |=> !rd_data[3]);

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!lin_rst_mode && wr_en && !wr_data[2] && !det_ovr) |=> !rd_data[2]);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!lin_rst_mode && wr_en && !wr_data[6] && det_par) |=> rd_data[6]);

    p_outs_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_par == rd_data[6]) && (flag_frm == rd_data[3]));
endmodule

bind lin_err_status lin_err_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lin_rst_mode (lin_rst_mode),
    .snooze       (snooze),
    .wake_rx_en   (wake_rx_en),
    .err_irq_off  (err_irq_off),
    .en_bit       (en_bit),
    .det_bit      (det_bit),
    .det_ovr      (det_ovr),
    .det_frm      (det_frm),
    .det_par      (det_par),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .flag_par     (flag_par),
    .flag_frm     (flag_frm)
);

// File: tb/lin_err_status_tb_top.sv
`timescale 1ns/1ps
module lin_err_status_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lin_rst_mode = 1'b0, snooze = 1'b0, wake_rx_en = 1'b0, err_irq_off = 1'b0;
    logic       en_bit = 1'b0, en_ovr = 1'b0, en_frm = 1'b0;
    logic       det_bit = 1'b0, det_ovr = 1'b0, det_frm = 1'b0;
    logic       det_exp = 1'b0, det_idm = 1'b0, det_par = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       flag_bit, flag_ovr, flag_frm, flag_exp, flag_idm, flag_par;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    lin_err_status dut_i (.*);

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] exp, input string req);
        logic [7:0] outs;
        outs = {1'b0, flag_par, flag_idm, flag_exp, flag_frm, flag_ovr, 1'b0, flag_bit};
        n_chk++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
        n_chk++;
        if (outs !== exp) begin
            n_bad++;
            $display("FAIL R10 (%s): flag outputs=%h expected=%h", req, outs, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        cyc();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic clear_all();
        wr(8'h00);
    endtask

    task automatic t_reset();
        chk(8'h00, "R1 reset value");
    endtask

    task automatic t_bit_err();
        clear_all();
        en_bit = 1'b0; det_bit = 1'b1; cyc(); det_bit = 1'b0;
        chk(8'h00, "R4 disabled bit error");
        en_bit = 1'b1; det_bit = 1'b1; cyc(); det_bit = 1'b0;
        chk(8'h01, "R4 enabled bit error at bit 0 (R1)");
        en_bit = 1'b0;
    endtask

    task automatic t_overrun();
        clear_all();
        en_ovr = 1'b0; det_ovr = 1'b1; cyc(); det_ovr = 1'b0;
        chk(8'h00, "R5 disabled overrun");
        en_ovr = 1'b1; det_ovr = 1'b1; cyc(); det_ovr = 1'b0;
        chk(8'h04, "R5 enabled overrun at bit 2");
        en_ovr = 1'b0;
    endtask

    task automatic t_framing();
        clear_all();
        en_frm = 1'b0; det_frm = 1'b1; cyc(); det_frm = 1'b0;
        chk(8'h00, "R6 disabled framing");
        en_frm = 1'b1; det_frm = 1'b1; cyc(); det_frm = 1'b0;
        chk(8'h08, "R6 enabled framing at bit 3");
        clear_all();
        snooze = 1'b1; wake_rx_en = 1'b0; err_irq_off = 1'b0;
        det_frm = 1'b1; cyc(); det_frm = 1'b0;
        chk(8'h00, "R6 snooze without wake enable");
        wake_rx_en = 1'b1; err_irq_off = 1'b1;
        det_frm = 1'b1; cyc(); det_frm = 1'b0;
        chk(8'h00, "R6 snooze with irq suppressed");
        err_irq_off = 1'b0;
        det_frm = 1'b1; cyc(); det_frm = 1'b0;
        chk(8'h08, "R6 snooze conditions met");
        snooze = 1'b0; wake_rx_en = 1'b0; en_frm = 1'b0;
    endtask

    task automatic t_direct();
        clear_all();
        det_exp = 1'b1; cyc(); det_exp = 1'b0;
        chk(8'h10, "R7 expansion bit at bit 4");
        det_idm = 1'b1; cyc(); det_idm = 1'b0;
        chk(8'h30, "R7 ID match at bit 5");
        det_par = 1'b1; cyc(); det_par = 1'b0;
        chk(8'h70, "R7 parity at bit 6");
    endtask

    task automatic fill_all();
        en_bit = 1'b1; en_ovr = 1'b1; en_frm = 1'b1;
        det_bit = 1'b1; det_ovr = 1'b1; det_frm = 1'b1;
        det_exp = 1'b1; det_idm = 1'b1; det_par = 1'b1;
        cyc();
        det_bit = 1'b0; det_ovr = 1'b0; det_frm = 1'b0;
        det_exp = 1'b0; det_idm = 1'b0; det_par = 1'b0;
        en_bit = 1'b0; en_ovr = 1'b0; en_frm = 1'b0;
    endtask

    task automatic t_write();
        fill_all();
        chk(8'h7D, "R1 all flags set");
        wr(8'hFF);
        chk(8'h7D, "R3 write ones keeps flags");
        wr(8'hFB);
        chk(8'h79, "R3 write zero clears overrun only");
        wr(8'hDE);
        chk(8'h58, "R3 clear bit error and ID match");
        clear_all();
        wr(8'h82);
        chk(8'h00, "R2 reserved bits read zero");
    endtask

    task automatic t_race();
        clear_all();
        det_par = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
        cyc();
        det_par = 1'b0; wr_en = 1'b0;
        chk(8'h40, "R8 detection beats clear");
    endtask

    task automatic t_lin_reset();
        fill_all();
        lin_rst_mode = 1'b1;
        cyc();
        chk(8'h00, "R9 entry clears register");
        en_bit = 1'b1;
        det_bit = 1'b1; det_par = 1'b1; det_exp = 1'b1; wr_en = 1'b1; wr_data = 8'hFF;
        cyc();
        det_bit = 1'b0; det_par = 1'b0; det_exp = 1'b0; wr_en = 1'b0; en_bit = 1'b0;
        chk(8'h00, "R9 pulses and writes ignored");
        lin_rst_mode = 1'b0;
        cyc();
        chk(8'h00, "R9 zero after leaving reset mode");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bit_err();
        t_overrun();
        t_framing();
        t_direct();
        t_write();
        t_race();
        t_lin_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule